// File: doc/BRIEF.md
# Egress packet transmit sequencer

This block moves packets one at a time from a queue scheduler to a DMA read channel. It asks the scheduler for the next packet. The answer gives a head segment address, a header length and a body length. The block then steps the DMA engine through its phases: open the channel, stream the data, close the channel. It ends each packet in one of two ways. It either frees the packet's segments, or it acknowledges a retransmission so that the segments are kept for a later resend.

Software controls the block through a small set of control inputs: an activate bit, a timeout enable and a retransmit request. Software can also launch a single raw packet whose address and lengths it supplies directly, which skips the scheduler. Faults and completions are reported as one-cycle event pulses. If the transmit path stays stalled by backpressure for a programmed number of prescaler ticks, the block raises a drain indication so that the queue can be emptied.

Top module: `egress_tx_seq`

## Requirements
- R1: `state_o` carries the phase as a 3-bit code: 0 idle, 1 schedule, 2 open, 3 transfer, 4 close, 5 free segments, 6 retransmit acknowledge. A normal packet with retransmit off visits 1, 2, 3, 4, 5 and then returns to 0.
- R2: The sequencer leaves idle only while the activate bit is set. If activate is cleared during a packet, that packet runs to completion and the block then stays in idle.
- R3: A schedule response whose header length and body length are both zero is discarded. The block returns to idle without opening the DMA channel and pulses `evt_o[4]`.
- R4: A schedule response whose head address is all ones (the NIL address) is discarded with a pulse on `evt_o[3]`. This check takes priority over the zero-length check, so the two never pulse together for one response.
- R5: `dma_nil` during transfer moves the block straight to the free-segments phase, skipping close. It also clears the activate bit and pulses `evt_o[2]`.
- R6: The retransmit request written by software (`rtx_shadow_o`) is copied into the working flag (`rtx_work_o`) only when a packet starts, that is, when the block leaves idle. When the working flag is set, the close phase is followed by phase 6 instead of phase 5.
- R7: A `raw_go` strobe captures the raw address, header length, offset and body length and sets `raw_busy_o`. A raw packet takes priority over scheduling, skips the schedule phase, and shows `ctx_raw`=1 with the raw context on the `ctx_*` outputs. When it finishes, the hardware clears `raw_busy_o` and pulses `evt_o[0]`.
- R8: With the timeout enabled and `tout_value` nonzero, `tx_stall` held during transfer for `tout_value` × `TICK_CYCLES` cycles pulses `evt_o[1]` once and sets `drain_o`. `drain_o` clears when the stall drops. A `tout_value` of 0 never times out.
- R9: `sch_port` presents `port_num` while scheduling. A port number equal to `NO_PORT` (default 71) means no port is assigned, and in that case no schedule request is issued.
- R10: After reset the block is idle with activate, raw busy, drain, all events and all requests at 0.
- R11: `dma_cmd_valid` is high only in phases 2, 4, 5 and 6, and `dma_cmd` carries the phase code. Each `dma_cmd_ack` advances exactly one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the three control bits below |
| ctl_act | input | 1 | Activate value written on `ctl_wr` |
| ctl_tout_en | input | 1 | Timeout enable value written on `ctl_wr` |
| ctl_rtx | input | 1 | Retransmit request value (shadow) written on `ctl_wr` |
| port_num | input | PORT_W | Egress port number; `NO_PORT` means unassigned |
| tout_value | input | TOUT_W | Inactivity limit in prescaler ticks; 0 disables the timeout |
| raw_go | input | 1 | Starts a raw transmit; ignored while one is pending |
| raw_head | input | ADDR_W | Raw packet head segment address |
| raw_hdr_len | input | HDR_W | Raw packet header length |
| raw_offset | input | OFFS_W | Raw packet offset into the segments |
| raw_body_len | input | BODY_W | Raw packet body length |
| sch_req | output | 1 | Schedule request, high in phase 1 |
| sch_port | output | PORT_W | Port number carried with the request |
| sch_valid | input | 1 | Schedule response valid |
| sch_head | input | ADDR_W | Response head segment address |
| sch_hdr_len | input | HDR_W | Response header length |
| sch_body_len | input | BODY_W | Response body length |
| dma_cmd_valid | output | 1 | DMA command request |
| dma_cmd | output | 3 | DMA command code (the phase code) |
| dma_cmd_ack | input | 1 | DMA command accepted |
| dma_done | input | 1 | Data transfer complete |
| dma_nil | input | 1 | DMA hit a NIL address in the segment list |
| tx_stall | input | 1 | Downstream backpressure |
| ctx_head | output | ADDR_W | Current packet head address |
| ctx_hdr_len | output | HDR_W | Current packet header length |
| ctx_offset | output | OFFS_W | Current packet offset (0 for scheduled packets) |
| ctx_body_len | output | BODY_W | Current packet body length |
| ctx_raw | output | 1 | Current packet is a raw packet |
| drain_o | output | 1 | Queue drain after a timeout |
| act_o | output | 1 | Activate bit |
| rtx_shadow_o | output | 1 | Retransmit request as written by software |
| rtx_work_o | output | 1 | Retransmit flag in use for the current packet |
| raw_busy_o | output | 1 | Raw transmit pending or in progress |
| state_o | output | 3 | Phase code |
| evt_o | output | 5 | Event pulses: 0 raw done, 1 timeout, 2 DMA NIL, 3 schedule NIL, 4 zero length |

## Verification
The hardest case to reach is the shadow behaviour of the retransmit request. It only shows when software changes the request while a packet has already started, and the effect appears one packet later. The bench writes the request while the block waits in the schedule phase for a response. It then checks that the packet in flight still frees its segments, and that only the following packet takes the acknowledge path. The timeout is reached by holding `tx_stall` while the bench's DMA model holds off `dma_done`. The bench then counts the cycles until the event pulse appears.

// File: rtl/egress_tx_pkg.sv
package egress_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SCHED  = 3'd1,
      ST_OPEN   = 3'd2,
      ST_XFER   = 3'd3,
      ST_CLOSE  = 3'd4,
      ST_FREE   = 3'd5,
      ST_RTXACK = 3'd6
   } tx_state_e;

   localparam int EV_W        = 5;
   localparam int EV_RAW_DONE = 0;
   localparam int EV_TOUT     = 1;
   localparam int EV_DMA_NIL  = 2;
   localparam int EV_SCH_NIL  = 3;
   localparam int EV_ZERO_LEN = 4;

endpackage

// File: rtl/egress_tx_timer.sv
module egress_tx_timer #(
   parameter int TOUT_W      = 16,
   parameter int TICK_CYCLES = 2859375
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [TOUT_W-1:0] limit,
   output logic              fire
);

   localparam logic [TOUT_W-1:0] ONE = TOUT_W'(1);

   logic              tick;
   logic [TOUT_W-1:0] tcnt_q;

   generate
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 1");
      end
      if (TICK_CYCLES > 1) begin : g_prescale
         localparam int PRE_W = $clog2(TICK_CYCLES);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (!run)   pre_q <= '0;
            else if (tick)   pre_q <= '0;
            else             pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_LAST);
      end else begin : g_direct
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tcnt_q <= '0;
      else if (!run)  tcnt_q <= '0;
      else if (tick)  tcnt_q <= tcnt_q + ONE;
   end

   assign fire = run && tick && (tcnt_q == limit - ONE);

endmodule

// File: rtl/egress_tx_ctl.sv
module egress_tx_ctl #(
   parameter int ADDR_W = 15,
   parameter int HDR_W  = 8,
   parameter int OFFS_W = 8,
   parameter int BODY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_act,
   input  logic              ctl_tout_en,
   input  logic              ctl_rtx,
   input  logic              act_clr,
   input  logic              pkt_start,
   input  logic              raw_go,
   input  logic [ADDR_W-1:0] raw_head,
   input  logic [HDR_W-1:0]  raw_hdr_len,
   input  logic [OFFS_W-1:0] raw_offset,
   input  logic [BODY_W-1:0] raw_body_len,
   input  logic              raw_clr,
   output logic              act_q,
   output logic              tout_en_q,
   output logic              rtx_shadow_q,
   output logic              rtx_work_q,
   output logic              raw_busy_q,
   output logic [ADDR_W-1:0] raw_head_q,
   output logic [HDR_W-1:0]  raw_hdr_q,
   output logic [OFFS_W-1:0] raw_offs_q,
   output logic [BODY_W-1:0] raw_body_q
);

   // activate: hardware clear wins over a write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q        <= 1'b0;
         tout_en_q    <= 1'b0;
         rtx_shadow_q <= 1'b0;
      end else begin
         if (act_clr)      act_q <= 1'b0;
         else if (ctl_wr)  act_q <= ctl_act;
         if (ctl_wr) begin
            tout_en_q    <= ctl_tout_en;
            rtx_shadow_q <= ctl_rtx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rtx_work_q <= 1'b0;
      else if (pkt_start) rtx_work_q <= rtx_shadow_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_busy_q <= 1'b0;
         raw_head_q <= '0;
         raw_hdr_q  <= '0;
         raw_offs_q <= '0;
         raw_body_q <= '0;
      end else if (raw_clr) begin
         raw_busy_q <= 1'b0;
      end else if (raw_go && !raw_busy_q) begin
         raw_busy_q <= 1'b1;
         raw_head_q <= raw_head;
         raw_hdr_q  <= raw_hdr_len;
         raw_offs_q <= raw_offset;
         raw_body_q <= raw_body_len;
      end
   end

endmodule

// File: rtl/egress_tx_fsm.sv
module egress_tx_fsm
   import egress_tx_pkg::*;
#(
   parameter int ADDR_W  = 15,
   parameter int PORT_W  = 7,
   parameter int NO_PORT = 71,
   parameter int HDR_W   = 8,
   parameter int OFFS_W  = 8,
   parameter int BODY_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              raw_busy,
   input  logic [ADDR_W-1:0] raw_head,
   input  logic [HDR_W-1:0]  raw_hdr,
   input  logic [OFFS_W-1:0] raw_offs,
   input  logic [BODY_W-1:0] raw_body,
   input  logic [PORT_W-1:0] port_num,
   input  logic              rtx_work,
   input  logic              sch_valid,
   input  logic [ADDR_W-1:0] sch_head,
   input  logic [HDR_W-1:0]  sch_hdr,
   input  logic [BODY_W-1:0] sch_body,
   input  logic              dma_cmd_ack,
   input  logic              dma_done,
   input  logic              dma_nil,
   input  logic              tout_fire,
   output tx_state_e         st_q,
   output logic              pkt_start,
   output logic              act_clr,
   output logic              raw_clr,
   output logic [EV_W-1:0]   ev_q,
   output logic [ADDR_W-1:0] ctx_head,
   output logic [HDR_W-1:0]  ctx_hdr,
   output logic [OFFS_W-1:0] ctx_offs,
   output logic [BODY_W-1:0] ctx_body,
   output logic              ctx_raw,
   output logic              sch_req,
   output logic              dma_cmd_valid
);

   localparam logic [ADDR_W-1:0] NIL_ADDR  = '1;
   localparam logic [PORT_W-1:0] NO_PORT_V = PORT_W'(NO_PORT);

   tx_state_e       nxt;
   logic [EV_W-1:0] ev_n;
   logic            load_sch, load_raw;

   always_comb begin
      nxt       = st_q;
      pkt_start = 1'b0;
      act_clr   = 1'b0;
      raw_clr   = 1'b0;
      load_sch  = 1'b0;
      load_raw  = 1'b0;
      ev_n      = '0;
      ev_n[EV_TOUT] = tout_fire;
      case (st_q)
         ST_IDLE:
            if (act && (raw_busy || port_num != NO_PORT_V)) begin
               pkt_start = 1'b1;
               if (raw_busy) begin
                  load_raw = 1'b1;
                  nxt      = ST_OPEN;
               end else begin
                  nxt      = ST_SCHED;
               end
            end
         ST_SCHED:
            if (sch_valid) begin
               if (sch_head == NIL_ADDR) begin
                  ev_n[EV_SCH_NIL] = 1'b1;
                  nxt = ST_IDLE;
               end else if (sch_hdr == '0 && sch_body == '0) begin
                  ev_n[EV_ZERO_LEN] = 1'b1;
                  nxt = ST_IDLE;
               end else begin
                  load_sch = 1'b1;
                  nxt      = ST_OPEN;
               end
            end
         ST_OPEN:
            if (dma_cmd_ack) nxt = ST_XFER;
         ST_XFER:
            if (dma_nil) begin
               ev_n[EV_DMA_NIL] = 1'b1;
               act_clr = 1'b1;
               nxt     = ST_FREE;
            end else if (dma_done) begin
               nxt = ST_CLOSE;
            end
         ST_CLOSE:
            if (dma_cmd_ack) nxt = rtx_work ? ST_RTXACK : ST_FREE;
         ST_FREE, ST_RTXACK:
            if (dma_cmd_ack) begin
               nxt = ST_IDLE;
               if (ctx_raw) begin
                  raw_clr = 1'b1;
                  ev_n[EV_RAW_DONE] = 1'b1;
               end
            end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ev_q <= '0;
      end else begin
         st_q <= nxt;
         ev_q <= ev_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_head <= '0;
         ctx_hdr  <= '0;
         ctx_offs <= '0;
         ctx_body <= '0;
         ctx_raw  <= 1'b0;
      end else if (load_raw) begin
         ctx_head <= raw_head;
         ctx_hdr  <= raw_hdr;
         ctx_offs <= raw_offs;
         ctx_body <= raw_body;
         ctx_raw  <= 1'b1;
      end else if (load_sch) begin
         ctx_head <= sch_head;
         ctx_hdr  <= sch_hdr;
         ctx_offs <= '0;
         ctx_body <= sch_body;
         ctx_raw  <= 1'b0;
      end
   end

   assign sch_req       = (st_q == ST_SCHED);
   assign dma_cmd_valid = (st_q == ST_OPEN) || (st_q == ST_CLOSE) ||
                          (st_q == ST_FREE) || (st_q == ST_RTXACK);

   // R3
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[EV_ZERO_LEN] |-> (st_q == ST_IDLE) && !ev_q[EV_SCH_NIL]);

   // R4
   sch_nil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q[EV_SCH_NIL] |-> (st_q == ST_IDLE) && ($past(st_q) == ST_SCHED));

   // R11
   cmd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cmd_valid && !dma_cmd_ack) |=> $stable(st_q));

endmodule

// File: rtl/egress_tx_seq.sv
module egress_tx_seq
   import egress_tx_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int PORT_W      = 7,
   parameter int NO_PORT     = 71,
   parameter int HDR_W       = 8,
   parameter int OFFS_W      = 8,
   parameter int BODY_W      = 16,
   parameter int TOUT_W      = 16,
   parameter int TICK_CYCLES = 2859375
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_act,
   input  logic              ctl_tout_en,
   input  logic              ctl_rtx,
   input  logic [PORT_W-1:0] port_num,
   input  logic [TOUT_W-1:0] tout_value,
   input  logic              raw_go,
   input  logic [ADDR_W-1:0] raw_head,
   input  logic [HDR_W-1:0]  raw_hdr_len,
   input  logic [OFFS_W-1:0] raw_offset,
   input  logic [BODY_W-1:0] raw_body_len,
   output logic              sch_req,
   output logic [PORT_W-1:0] sch_port,
   input  logic              sch_valid,
   input  logic [ADDR_W-1:0] sch_head,
   input  logic [HDR_W-1:0]  sch_hdr_len,
   input  logic [BODY_W-1:0] sch_body_len,
   output logic              dma_cmd_valid,
   output logic [2:0]        dma_cmd,
   input  logic              dma_cmd_ack,
   input  logic              dma_done,
   input  logic              dma_nil,
   input  logic              tx_stall,
   output logic [ADDR_W-1:0] ctx_head,
   output logic [HDR_W-1:0]  ctx_hdr_len,
   output logic [OFFS_W-1:0] ctx_offset,
   output logic [BODY_W-1:0] ctx_body_len,
   output logic              ctx_raw,
   output logic              drain_o,
   output logic              act_o,
   output logic              rtx_shadow_o,
   output logic              rtx_work_o,
   output logic              raw_busy_o,
   output logic [2:0]        state_o,
   output logic [EV_W-1:0]   evt_o
);

   generate
      if (NO_PORT < 0 || NO_PORT >= (1 << PORT_W)) begin : g_bad_port
         $error("NO_PORT must fit in PORT_W bits");
      end
      if (ADDR_W < 2 || TOUT_W < 1) begin : g_bad_width
         $error("ADDR_W and TOUT_W out of range");
      end
   endgenerate

   tx_state_e         st;
   logic              pkt_start, act_clr, raw_clr, tout_en, fire, run, drain_q;
   logic [ADDR_W-1:0] r_head;
   logic [HDR_W-1:0]  r_hdr;
   logic [OFFS_W-1:0] r_offs;
   logic [BODY_W-1:0] r_body;

   egress_tx_ctl #(
      .ADDR_W(ADDR_W), .HDR_W(HDR_W), .OFFS_W(OFFS_W), .BODY_W(BODY_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_act(ctl_act), .ctl_tout_en(ctl_tout_en), .ctl_rtx(ctl_rtx),
      .act_clr(act_clr), .pkt_start(pkt_start),
      .raw_go(raw_go), .raw_head(raw_head), .raw_hdr_len(raw_hdr_len),
      .raw_offset(raw_offset), .raw_body_len(raw_body_len), .raw_clr(raw_clr),
      .act_q(act_o), .tout_en_q(tout_en), .rtx_shadow_q(rtx_shadow_o),
      .rtx_work_q(rtx_work_o), .raw_busy_q(raw_busy_o),
      .raw_head_q(r_head), .raw_hdr_q(r_hdr), .raw_offs_q(r_offs), .raw_body_q(r_body)
   );

   egress_tx_fsm #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .NO_PORT(NO_PORT),
      .HDR_W(HDR_W), .OFFS_W(OFFS_W), .BODY_W(BODY_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .act(act_o), .raw_busy(raw_busy_o),
      .raw_head(r_head), .raw_hdr(r_hdr), .raw_offs(r_offs), .raw_body(r_body),
      .port_num(port_num), .rtx_work(rtx_work_o),
      .sch_valid(sch_valid), .sch_head(sch_head), .sch_hdr(sch_hdr_len), .sch_body(sch_body_len),
      .dma_cmd_ack(dma_cmd_ack), .dma_done(dma_done), .dma_nil(dma_nil),
      .tout_fire(fire),
      .st_q(st), .pkt_start(pkt_start), .act_clr(act_clr), .raw_clr(raw_clr),
      .ev_q(evt_o),
      .ctx_head(ctx_head), .ctx_hdr(ctx_hdr_len), .ctx_offs(ctx_offset),
      .ctx_body(ctx_body_len), .ctx_raw(ctx_raw),
      .sch_req(sch_req), .dma_cmd_valid(dma_cmd_valid)
   );

   assign run = tout_en && (tout_value != '0) && (st == ST_XFER) && tx_stall && !drain_q;

   egress_tx_timer #(
      .TOUT_W(TOUT_W), .TICK_CYCLES(TICK_CYCLES)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .limit(tout_value), .fire(fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         drain_q <= 1'b0;
      else if (fire)      drain_q <= 1'b1;
      else if (!tx_stall) drain_q <= 1'b0;
   end

   assign drain_o  = drain_q;
   assign state_o  = st;
   assign dma_cmd  = st;
   assign sch_port = port_num;

   // R5
   dma_nil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[EV_DMA_NIL] |-> !act_o && (st == ST_FREE));

   // R6
   rtx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) != ST_IDLE) |-> $stable(rtx_work_o));

   // R7
   raw_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[EV_RAW_DONE] |-> !raw_busy_o && (st == ST_IDLE));

   // R8
   tout_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[EV_TOUT] |-> drain_o);

   // R9
   no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && port_num == PORT_W'(NO_PORT) && !raw_busy_o) |=> (st != ST_SCHED));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !act_o) |=> (st == ST_IDLE));

endmodule

// File: tb/egress_tx_seq_bench.sv
module egress_tx_seq_bench;
   import egress_tx_pkg::*;

   localparam int TICK = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        ctl_wr = 0, ctl_act = 0, ctl_tout_en = 0, ctl_rtx = 0;
   logic [6:0]  port_num = 7'd5;
   logic [15:0] tout_value = 16'd0;
   logic        raw_go = 0;
   logic [14:0] raw_head = '0;
   logic [7:0]  raw_hdr_len = '0, raw_offset = '0;
   logic [15:0] raw_body_len = '0;
   logic        sch_req, sch_valid = 0;
   logic [6:0]  sch_port;
   logic [14:0] sch_head = '0;
   logic [7:0]  sch_hdr_len = '0;
   logic [15:0] sch_body_len = '0;
   logic        dma_cmd_valid, dma_cmd_ack = 0, dma_done = 0, dma_nil = 0, tx_stall = 0;
   logic [2:0]  dma_cmd;
   logic [14:0] ctx_head;
   logic [7:0]  ctx_hdr_len, ctx_offset;
   logic [15:0] ctx_body_len;
   logic        ctx_raw, drain_o, act_o, rtx_shadow_o, rtx_work_o, raw_busy_o;
   logic [2:0]  state_o;
   logic [4:0]  evt_o;

   egress_tx_seq #(.TICK_CYCLES(TICK)) u_egress_tx_seq (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_act(ctl_act), .ctl_tout_en(ctl_tout_en), .ctl_rtx(ctl_rtx),
      .port_num(port_num), .tout_value(tout_value),
      .raw_go(raw_go), .raw_head(raw_head), .raw_hdr_len(raw_hdr_len),
      .raw_offset(raw_offset), .raw_body_len(raw_body_len),
      .sch_req(sch_req), .sch_port(sch_port), .sch_valid(sch_valid), .sch_head(sch_head),
      .sch_hdr_len(sch_hdr_len), .sch_body_len(sch_body_len),
      .dma_cmd_valid(dma_cmd_valid), .dma_cmd(dma_cmd), .dma_cmd_ack(dma_cmd_ack),
      .dma_done(dma_done), .dma_nil(dma_nil), .tx_stall(tx_stall),
      .ctx_head(ctx_head), .ctx_hdr_len(ctx_hdr_len), .ctx_offset(ctx_offset),
      .ctx_body_len(ctx_body_len), .ctx_raw(ctx_raw), .drain_o(drain_o),
      .act_o(act_o), .rtx_shadow_o(rtx_shadow_o), .rtx_work_o(rtx_work_o),
      .raw_busy_o(raw_busy_o), .state_o(state_o), .evt_o(evt_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(string req, string what, logic [31:0] actual, logic [31:0] expected);
      n_chk++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
      end
   endtask

   // ---------------- monitor: state order, event counts, request counts
   logic [2:0] seq [16];
   int         seq_n = 0;
   logic [2:0] last_st = 3'd0;
   int         ev_cnt [5] = '{0, 0, 0, 0, 0};
   int         req_cnt = 0;

   initial forever begin
      @(negedge clk);
      if (state_o != last_st) begin
         if (seq_n < 16) seq[seq_n] = state_o;
         seq_n++;
         last_st = state_o;
      end
      for (int i = 0; i < 5; i++) if (evt_o[i]) ev_cnt[i]++;
      if (sch_req) req_cnt++;
   end

   task automatic mark();
      seq_n   = 1;
      seq[0]  = state_o;
      last_st = state_o;
   endtask

   task automatic check_seq(string req, int n, logic [47:0] expv);
      logic [47:0] got = '0;
      for (int i = 0; i < n && i < 16; i++) got[3*(n-1-i) +: 3] = seq[i];
      n_chk++;
      if (seq_n != n || got != expv) begin
         n_fail++;
         $display("FAIL %s state order: actual %0h (%0d steps) expected %0h (%0d steps)",
                  req, got, seq_n, expv, n);
      end
   endtask

   // ---------------- scheduler model
   logic        rsp_pend = 0;
   logic [14:0] rsp_head = '0;
   logic [7:0]  rsp_hdr = '0;
   logic [15:0] rsp_body = '0;

   initial forever begin
      @(negedge clk);
      if (sch_req && rsp_pend && !sch_valid) begin
         sch_valid = 1; sch_head = rsp_head; sch_hdr_len = rsp_hdr; sch_body_len = rsp_body;
         rsp_pend = 0;
      end else begin
         sch_valid = 0;
      end
   end

   // ---------------- DMA model: 0 finish, 1 NIL fault, 2 finish on release
   int   tx_mode = 0;
   logic tx_release = 0;
   int   tx_cnt = 0;

   initial forever begin
      @(negedge clk);
      dma_cmd_ack = dma_cmd_valid;
      dma_done = 0;
      dma_nil  = 0;
      if (state_o == 3'd3) begin
         tx_cnt++;
         if (tx_cnt >= 2) begin
            if (tx_mode == 0) dma_done = 1;
            else if (tx_mode == 1) dma_nil = 1;
            else if (tx_release) dma_done = 1;
         end
      end else begin
         tx_cnt = 0;
      end
   end

   task automatic respond(logic [14:0] h, logic [7:0] hl, logic [15:0] bl);
      rsp_head = h; rsp_hdr = hl; rsp_body = bl; rsp_pend = 1;
   endtask

   task automatic write_ctl(logic a, logic t, logic r);
      @(negedge clk);
      ctl_wr = 1; ctl_act = a; ctl_tout_en = t; ctl_rtx = r;
      @(negedge clk);
      ctl_wr = 0;
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_state(logic [2:0] s);
      for (int i = 0; i < 200 && state_o != s; i++) @(negedge clk);
   endtask

   // ---------------- scenarios
   task automatic t_reset();
      chk("R10", "state", state_o, 0);
      chk("R10", "act", act_o, 0);
      chk("R10", "raw busy", raw_busy_o, 0);
      chk("R10", "requests", {sch_req, dma_cmd_valid, drain_o}, 0);
      chk("R10", "events", evt_o, 0);
   endtask

   task automatic t_basic();
      write_ctl(1, 0, 0);
      wait_state(3'd1);
      chk("R9", "port on request", sch_port, 5);
      mark();
      respond(15'h0123, 8'd14, 16'd100);
      wait_state(3'd2);
      chk("R11", "open command", {dma_cmd_valid, dma_cmd}, {1'b1, 3'd2});
      chk("R11", "context head", ctx_head, 15'h0123);
      chk("R11", "context lengths", {ctx_hdr_len, ctx_offset, ctx_body_len}, {8'd14, 8'd0, 16'd100});
      wait_state(3'd3);
      chk("R11", "no command in transfer", dma_cmd_valid, 0);
      cycles(20);
      check_seq("R1", 7, {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd1});
   endtask

   task automatic t_rtx();
      write_ctl(1, 0, 1);
      chk("R6", "shadow written", rtx_shadow_o, 1);
      chk("R6", "working unchanged mid packet", rtx_work_o, 0);
      mark();
      respond(15'h0200, 8'd8, 16'd40);
      cycles(20);
      check_seq("R6", 7, {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd1});
      chk("R6", "working loaded at start", rtx_work_o, 1);
      mark();
      respond(15'h0210, 8'd8, 16'd40);
      cycles(20);
      check_seq("R6", 7, {3'd1, 3'd2, 3'd3, 3'd4, 3'd6, 3'd0, 3'd1});
      write_ctl(1, 0, 0);
   endtask

   task automatic t_zero();
      int z0 = ev_cnt[EV_ZERO_LEN];
      mark();
      respond(15'h0033, 8'd0, 16'd0);
      cycles(8);
      check_seq("R3", 3, {3'd1, 3'd0, 3'd1});
      chk("R3", "zero length event", ev_cnt[EV_ZERO_LEN] - z0, 1);
      chk("R3", "working shadow reloaded", rtx_work_o, 0);
   endtask

   task automatic t_nil();
      int z0 = ev_cnt[EV_ZERO_LEN];
      int n0 = ev_cnt[EV_SCH_NIL];
      mark();
      respond(15'h7FFF, 8'd0, 16'd0);
      cycles(8);
      check_seq("R4", 3, {3'd1, 3'd0, 3'd1});
      chk("R4", "nil event", ev_cnt[EV_SCH_NIL] - n0, 1);
      chk("R4", "no zero event with nil", ev_cnt[EV_ZERO_LEN] - z0, 0);
   endtask

   task automatic t_deact();
      mark();
      tx_mode = 2; tx_release = 0;
      respond(15'h0040, 8'd4, 16'd60);
      wait_state(3'd3);
      write_ctl(0, 0, 0);
      cycles(5);
      chk("R2", "frame held in transfer", state_o, 3);
      tx_release = 1;
      cycles(10);
      check_seq("R2", 6, {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0});
      cycles(10);
      chk("R2", "holds idle after finish", {state_o, sch_req}, 0);
      tx_mode = 0; tx_release = 0;
   endtask

   task automatic t_dnil();
      int d0;
      write_ctl(1, 0, 0);
      wait_state(3'd1);
      d0 = ev_cnt[EV_DMA_NIL];
      mark();
      tx_mode = 1;
      respond(15'h0500, 8'd10, 16'd300);
      cycles(20);
      check_seq("R5", 5, {3'd1, 3'd2, 3'd3, 3'd5, 3'd0});
      chk("R5", "activate cleared", act_o, 0);
      chk("R5", "dma nil event", ev_cnt[EV_DMA_NIL] - d0, 1);
      tx_mode = 0;
   endtask

   task automatic t_raw();
      int r0 = ev_cnt[EV_RAW_DONE];
      int q0;
      port_num = 7'd71;
      @(negedge clk);
      raw_go = 1; raw_head = 15'h0055; raw_hdr_len = 8'd8; raw_offset = 8'd3; raw_body_len = 16'd200;
      @(negedge clk);
      raw_go = 0;
      cycles(5);
      chk("R2", "raw waits for activate", state_o, 0);
      chk("R7", "raw bit set", raw_busy_o, 1);
      mark();
      write_ctl(1, 0, 0);
      wait_state(3'd2);
      chk("R7", "raw context", {ctx_raw, ctx_offset, ctx_hdr_len}, {1'b1, 8'd3, 8'd8});
      chk("R7", "raw addr and body", {ctx_head, ctx_body_len}, {15'h0055, 16'd200});
      cycles(15);
      check_seq("R7", 6, {3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0});
      chk("R7", "raw bit cleared", raw_busy_o, 0);
      chk("R7", "raw done event", ev_cnt[EV_RAW_DONE] - r0, 1);
      q0 = req_cnt;
      cycles(20);
      chk("R9", "no request without port", req_cnt - q0, 0);
   endtask

   task automatic t_tout();
      int n = 1;
      int t0 = ev_cnt[EV_TOUT];
      port_num = 7'd5;
      tout_value = 16'd3;
      tx_mode = 2; tx_release = 0; tx_stall = 1;
      write_ctl(1, 1, 0);
      wait_state(3'd1);
      respond(15'h0600, 8'd6, 16'd64);
      wait_state(3'd3);
      while (!evt_o[EV_TOUT] && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R8", "timeout cycle window", (n >= 3*TICK && n <= 3*TICK+2), 1);
      chk("R8", "drain set", drain_o, 1);
      cycles(20);
      chk("R8", "single timeout event", ev_cnt[EV_TOUT] - t0, 1);
      tx_stall = 0;
      cycles(2);
      chk("R8", "drain cleared", drain_o, 0);
      tx_release = 1;
      wait_state(3'd1);
      tx_release = 0;
      tout_value = 16'd0;
      tx_stall = 1;
      t0 = ev_cnt[EV_TOUT];
      respond(15'h0610, 8'd6, 16'd64);
      wait_state(3'd3);
      cycles(40);
      chk("R8", "zero value never times out", {ev_cnt[EV_TOUT] - t0, 31'(drain_o)}, 0);
      tx_stall = 0;
      tx_release = 1;
      wait_state(3'd1);
      tx_release = 0; tx_mode = 0;
   endtask

   // ---------------- watchdog
   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1;
      cycles(1);
      t_reset();
      t_basic();
      t_rtx();
      t_zero();
      t_nil();
      t_deact();
      t_dnil();
      t_raw();
      t_tout();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule